// File: doc/BRIEF.md
# Load-Feedback Replay Cost Controller

This block is the slow outer loop that tunes how aggressive a predicted-wakeup scheduler may be. Each cycle it receives, for every functional-unit class, the number of useful issues, the number of useless (later replayed) issues and the number of units in that class. From these it forms per-class load samples and smooths them into exponential running averages.

Once per fixed window it looks at the class with the highest total load and compares its useful load with a useful-only threshold and its total load with a lower target threshold. The outcome raises, lowers or holds the modelled replay cost r. The cost is always a power of two, kept as a sign bit and a signed exponent, so the wakeup predictor can apply it with a shift. When shrinking would push the magnitude below the floor, the magnitude is kept and the sign inverts instead. While r is negative, the meaning of each step is mirrored.

Top module: `replay_cost_ctrl`

## Requirements
- R1: A synchronous active-high reset sets r to +1 (r_neg = 0, r_exp = 0), clears every running average and restarts the window counter.
- R2: Each class forms a sample equal to floor(count * 256 / units), or 0 when units is 0, and updates its average as avg - (avg >> EMA_SHIFT) + (sample >> EMA_SHIFT), held separately for useful and useless counts.
- R3: Only the class with the largest total (useful plus useless average) is judged, and on a tie the lowest class index wins.
- R4: If the judged class has a useful average below USEFUL_ONLY_LOAD and a total below TARGET_LOAD, r is lowered.
- R5: If the judged class has a useful average below USEFUL_ONLY_LOAD and a total at or above TARGET_LOAD, r is raised.
- R6: If the judged useful average is at or above USEFUL_ONLY_LOAD, r is raised when its useless average is non-zero and held otherwise.
- R7: r changes only on the clock edge that ends each window of INTERVAL cycles; the first such edge is the INTERVAL-th edge after reset is released, and r is constant on all other edges.
- R8: Raising a positive r adds one to r_exp, saturating at EXP_MAX; raising a negative r halves its magnitude (r_exp minus one).
- R9: Lowering a positive r subtracts one from r_exp; lowering a negative r doubles its magnitude, saturating at EXP_MAX.
- R10: A step that would bring r_exp below EXP_MIN leaves r_exp at EXP_MIN and inverts r_neg.
- R11: The output encodes r = (-1)^r_neg * 2^r_exp, with r_exp a two's complement value that stays within EXP_MIN to EXP_MAX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| useful_cnt | input | NUM_CLASS*CNT_W | Useful issues this cycle, one CNT_W field per class, class 0 in the low bits |
| useless_cnt | input | NUM_CLASS*CNT_W | Replayed issues this cycle, one field per class |
| unit_cnt | input | NUM_CLASS*UNIT_W | Number of units in each class |
| r_neg | output | 1 | Sign of the replay cost, 1 when negative |
| r_exp | output | 5 | Signed power-of-two exponent of the replay cost magnitude |

## Verification
A corrupted running average or a wrong class choice stays invisible until the end of the current window, and then shows up as a step in the wrong direction or a missing step on r. The bench therefore compares r on every cycle against a model built from the requirements, so any stray change between window edges is caught on the very next cycle. Faults in the sign or saturation logic show only when r is driven to the floor or the ceiling, so the stimulus pushes r through both limits and through sign inversion in each direction.

// File: rtl/rcc_pkg.sv
package rcc_pkg;

    localparam int FRAC_W = 8;
    localparam int EXP_W  = 5;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

    typedef struct packed {
        logic                    neg;
        logic signed [EXP_W-1:0] exp;
    } rcost_t;

    // Apply one raise/lower step to a sign-magnitude power-of-two cost.
    function automatic rcost_t rcost_step(rcost_t cur, step_e st, int emin, int emax);
        rcost_t nxt;
        logic   grow;
        logic   shrink;
        nxt    = cur;
        grow   = (st == STEP_UP && !cur.neg) || (st == STEP_DOWN && cur.neg);
        shrink = (st == STEP_UP && cur.neg) || (st == STEP_DOWN && !cur.neg);
        if (grow) begin
            if (int'(cur.exp) < emax) nxt.exp = EXP_W'(int'(cur.exp) + 1);
        end else if (shrink) begin
            if (int'(cur.exp) > emin) nxt.exp = EXP_W'(int'(cur.exp) - 1);
            else                      nxt.neg = ~cur.neg;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/rcc_class_avg.sv
module rcc_class_avg import rcc_pkg::*; #(
    parameter int CNT_W     = 4,
    parameter int UNIT_W    = 3,
    parameter int EMA_SHIFT = 4,
    localparam int AVG_W    = CNT_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [UNIT_W-1:0] units,
    output logic [AVG_W-1:0]  avg
);

    localparam logic [AVG_W-1:0] AVG_MAX = {{CNT_W{1'b1}}, {FRAC_W{1'b0}}};

    logic [AVG_W-1:0] sample;
    logic [AVG_W-1:0] avg_q;

    always_comb begin
        if (units == '0) sample = '0;
        else             sample = {cnt, {FRAC_W{1'b0}}} / AVG_W'(units);
    end

    always_ff @(posedge clk) begin
        if (rst) avg_q <= '0;
        else     avg_q <= avg_q - (avg_q >> EMA_SHIFT) + (sample >> EMA_SHIFT);
    end

    assign avg = avg_q;

    // R2: the average can never exceed the largest possible sample
    a_r2_avg_bound: assert property (@(posedge clk) disable iff (rst)
        avg_q <= AVG_MAX);

    // R2: a class with no units contributes a zero sample, so it only decays
    a_r2_zero_units_decay: assert property (@(posedge clk) disable iff (rst)
        (units == '0) |=> (avg_q <= $past(avg_q)));

endmodule

// File: rtl/rcc_peak_pick.sv
module rcc_peak_pick #(
    parameter int NUM_CLASS = 3,
    parameter int AVG_W     = 12
) (
    input  logic [AVG_W-1:0] useful_avg  [NUM_CLASS],
    input  logic [AVG_W-1:0] useless_avg [NUM_CLASS],
    output logic [AVG_W-1:0] pk_useful,
    output logic [AVG_W-1:0] pk_useless,
    output logic [AVG_W:0]   pk_total
);

    always_comb begin
        logic [AVG_W:0] t;
        pk_useful  = useful_avg[0];
        pk_useless = useless_avg[0];
        pk_total   = {1'b0, useful_avg[0]} + {1'b0, useless_avg[0]};
        for (int i = 1; i < NUM_CLASS; i++) begin
            t = {1'b0, useful_avg[i]} + {1'b0, useless_avg[i]};
            // strict compare keeps the lowest index on a tie (R3)
            if (t > pk_total) begin
                pk_useful  = useful_avg[i];
                pk_useless = useless_avg[i];
                pk_total   = t;
            end
        end
    end

    // R3: the judged class carries the highest total of all classes
    always_comb begin
        for (int i = 0; i < NUM_CLASS; i++) begin
            a_r3_peak_max: assert (({1'b0, useful_avg[i]} + {1'b0, useless_avg[i]}) <= pk_total);
        end
    end

endmodule

// File: rtl/rcc_cost_reg.sv
module rcc_cost_reg import rcc_pkg::*; #(
    parameter int INTERVAL         = 1000,
    parameter int AVG_W            = 12,
    parameter int TARGET_LOAD      = 205,
    parameter int USEFUL_ONLY_LOAD = 230,
    parameter int EXP_MIN          = -2,
    parameter int EXP_MAX          = 6,
    localparam int IVL_W           = (INTERVAL > 2) ? $clog2(INTERVAL) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AVG_W-1:0] pk_useful,
    input  logic [AVG_W-1:0] pk_useless,
    input  logic [AVG_W:0]   pk_total,
    output rcost_t           r
);

    localparam logic [IVL_W-1:0] IVL_LAST = IVL_W'(INTERVAL - 1);
    localparam logic [AVG_W:0]   TGT_V    = (AVG_W + 1)'(TARGET_LOAD);
    localparam logic [AVG_W-1:0] UO_V     = AVG_W'(USEFUL_ONLY_LOAD);

    logic [IVL_W-1:0] ivl_q;
    logic             tick;
    step_e            step;
    rcost_t           r_q;

    assign tick = (ivl_q == IVL_LAST);

    always_comb begin
        if (pk_useful < UO_V) step = (pk_total < TGT_V) ? STEP_DOWN : STEP_UP;
        else                  step = (pk_useless != '0) ? STEP_UP : STEP_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ivl_q <= '0;
            r_q   <= '{neg: 1'b0, exp: '0};
        end else if (tick) begin
            ivl_q <= '0;
            r_q   <= rcost_step(r_q, step, EXP_MIN, EXP_MAX);
        end else begin
            ivl_q <= ivl_q + 1'b1;
        end
    end

    assign r = r_q;

    // R1: one edge of reset leaves r at +1
    a_r1_reset_value: assert property (@(posedge clk)
        $past(rst) |-> (!r_q.neg && r_q.exp == '0));

    // R7: between window edges r does not move
    a_r7_hold_between: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(r_q));

    // R11: exponent stays inside its legal span
    a_r11_exp_range: assert property (@(posedge clk) disable iff (rst)
        (int'(r_q.exp) >= EXP_MIN) && (int'(r_q.exp) <= EXP_MAX));

    // R10: the sign only turns over at the floor exponent
    a_r10_flip_at_floor: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(r_q.neg)) |->
            (int'(r_q.exp) == EXP_MIN && int'($past(r_q.exp)) == EXP_MIN));

endmodule

// File: rtl/replay_cost_ctrl.sv
module replay_cost_ctrl import rcc_pkg::*; #(
    parameter int NUM_CLASS        = 3,
    parameter int CNT_W            = 4,
    parameter int UNIT_W           = 3,
    parameter int EMA_SHIFT        = 4,
    parameter int INTERVAL         = 1000,
    parameter int TARGET_LOAD      = 205,
    parameter int USEFUL_ONLY_LOAD = 230,
    parameter int EXP_MIN          = -2,
    parameter int EXP_MAX          = 6
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_CLASS*CNT_W-1:0]  useful_cnt,
    input  logic [NUM_CLASS*CNT_W-1:0]  useless_cnt,
    input  logic [NUM_CLASS*UNIT_W-1:0] unit_cnt,
    output logic                        r_neg,
    output logic signed [EXP_W-1:0]     r_exp
);

    localparam int AVG_W = CNT_W + FRAC_W;

    logic [AVG_W-1:0] useful_avg  [NUM_CLASS];
    logic [AVG_W-1:0] useless_avg [NUM_CLASS];
    logic [AVG_W-1:0] pk_useful;
    logic [AVG_W-1:0] pk_useless;
    logic [AVG_W:0]   pk_total;
    rcost_t           r;

    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_class
        rcc_class_avg #(
            .CNT_W(CNT_W), .UNIT_W(UNIT_W), .EMA_SHIFT(EMA_SHIFT)
        ) u_useful (
            .clk  (clk),
            .rst  (rst),
            .cnt  (useful_cnt[c*CNT_W +: CNT_W]),
            .units(unit_cnt[c*UNIT_W +: UNIT_W]),
            .avg  (useful_avg[c])
        );
        rcc_class_avg #(
            .CNT_W(CNT_W), .UNIT_W(UNIT_W), .EMA_SHIFT(EMA_SHIFT)
        ) u_useless (
            .clk  (clk),
            .rst  (rst),
            .cnt  (useless_cnt[c*CNT_W +: CNT_W]),
            .units(unit_cnt[c*UNIT_W +: UNIT_W]),
            .avg  (useless_avg[c])
        );
    end

    rcc_peak_pick #(.NUM_CLASS(NUM_CLASS), .AVG_W(AVG_W)) u_peak (
        .useful_avg (useful_avg),
        .useless_avg(useless_avg),
        .pk_useful  (pk_useful),
        .pk_useless (pk_useless),
        .pk_total   (pk_total)
    );

    rcc_cost_reg #(
        .INTERVAL(INTERVAL), .AVG_W(AVG_W),
        .TARGET_LOAD(TARGET_LOAD), .USEFUL_ONLY_LOAD(USEFUL_ONLY_LOAD),
        .EXP_MIN(EXP_MIN), .EXP_MAX(EXP_MAX)
    ) u_cost (
        .clk       (clk),
        .rst       (rst),
        .pk_useful (pk_useful),
        .pk_useless(pk_useless),
        .pk_total  (pk_total),
        .r         (r)
    );

    assign r_neg = r.neg;
    assign r_exp = r.exp;

endmodule

// File: tb/replay_cost_ctrl_tb_top.sv
`timescale 1ns/1ps
module replay_cost_ctrl_tb_top;

    localparam int NC   = 3;
    localparam int CW   = 4;
    localparam int UW   = 3;
    localparam int IV   = 24;
    localparam int TGT  = 205;
    localparam int UO   = 230;
    localparam int EMIN = -2;
    localparam int EMAX = 6;

    // stimulus table: per-class useful, useless, units, held for TI windows
    localparam int NV = 6;
    localparam int TU [NV][NC] = '{'{1,0,1}, '{3,0,0}, '{7,7,7}, '{7,0,0}, '{2,1,1}, '{3,0,7}};
    localparam int TX [NV][NC] = '{'{0,0,0}, '{1,0,0}, '{0,0,0}, '{1,0,0}, '{0,1,1}, '{1,0,0}};
    localparam int TN [NV][NC] = '{'{4,4,4}, '{4,4,4}, '{7,7,7}, '{7,7,7}, '{0,4,4}, '{4,4,6}};
    localparam int TI [NV]     = '{8, 12, 4, 10, 6, 4};

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic [NC*CW-1:0]      useful_cnt = '0;
    logic [NC*CW-1:0]      useless_cnt = '0;
    logic [NC*UW-1:0]      unit_cnt = '0;
    logic                  r_neg;
    logic signed [4:0]     r_exp;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    int cu [NC];
    int cx [NC];
    int cn [NC];
    int mu [NC];
    int mx [NC];
    int mcnt = 0;
    int mneg = 0;
    int mexp = 0;

    always #2.5 clk = ~clk;

    replay_cost_ctrl #(
        .NUM_CLASS(NC), .CNT_W(CW), .UNIT_W(UW), .EMA_SHIFT(4), .INTERVAL(IV),
        .TARGET_LOAD(TGT), .USEFUL_ONLY_LOAD(UO), .EXP_MIN(EMIN), .EXP_MAX(EMAX)
    ) dut_i (
        .clk(clk), .rst(rst), .useful_cnt(useful_cnt), .useless_cnt(useless_cnt),
        .unit_cnt(unit_cnt), .r_neg(r_neg), .r_exp(r_exp)
    );

    task automatic check(input bit ok, input string tag);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got r_neg=%0d r_exp=%0d, expected r_neg=%0d r_exp=%0d",
                     tag, r_neg, r_exp, mneg, mexp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NC; i++) begin mu[i] = 0; mx[i] = 0; end
        mcnt = 0; mneg = 0; mexp = 0;
    endtask

    // one clock: drive, predict from the requirements, then compare
    task automatic one_cycle();
        bit    is_tick;
        int    best;
        int    bt;
        int    grow;
        int    shrink;
        string tag;
        for (int i = 0; i < NC; i++) begin
            useful_cnt[i*CW +: CW]  = CW'(cu[i]);
            useless_cnt[i*CW +: CW] = CW'(cx[i]);
            unit_cnt[i*UW +: UW]    = UW'(cn[i]);
        end
        is_tick = (mcnt == IV - 1);
        tag = "R7 hold";
        if (is_tick) begin
            // R3: highest total, lowest index on a tie
            best = 0; bt = mu[0] + mx[0];
            for (int i = 1; i < NC; i++) if (mu[i] + mx[i] > bt) begin best = i; bt = mu[i] + mx[i]; end
            grow = 0; shrink = 0;
            if (mu[best] < UO) begin
                if (bt < TGT) begin tag = "R4 lower"; if (mneg) grow = 1; else shrink = 1; end
                else          begin tag = "R5 raise"; if (mneg) shrink = 1; else grow = 1; end
            end else if (mx[best] != 0) begin
                tag = "R6 raise"; if (mneg) shrink = 1; else grow = 1;
            end else tag = "R6 hold";
            if (grow) begin
                tag = {tag, mneg ? " R9" : " R8"};
                if (mexp < EMAX) mexp++;
            end else if (shrink) begin
                tag = {tag, mneg ? " R8" : " R9"};
                if (mexp > EMIN) mexp--;
                else begin mneg = !mneg; tag = {tag, " R10"}; end
            end
        end
        // R2: sample and exponential average
        for (int i = 0; i < NC; i++) begin
            int su;
            int sx;
            su = (cn[i] == 0) ? 0 : (cu[i] * 256) / cn[i];
            sx = (cn[i] == 0) ? 0 : (cx[i] * 256) / cn[i];
            mu[i] = mu[i] - (mu[i] >> 4) + (su >> 4);
            mx[i] = mx[i] - (mx[i] >> 4) + (sx >> 4);
        end
        mcnt = is_tick ? 0 : mcnt + 1;
        @(posedge clk); #2;
        check(r_neg == 1'(mneg) && int'(r_exp) == mexp, tag);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: got no end of test, expected completion");
        if (!done) begin
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NC; i++) begin cu[i] = 0; cx[i] = 0; cn[i] = 0; end
        model_reset();
        repeat (3) @(posedge clk);
        #2;
        check(r_neg == 1'b0 && r_exp == 5'sd0, "R1/R11 reset value");
        rst = 1'b0;

        // table walk: low load, crowding, clean saturation, replays at saturation,
        // ties with a zero-unit class (R2, R3), and a lower-index class that loses (R3)
        for (int v = 0; v < NV; v++) begin
            for (int i = 0; i < NC; i++) begin cu[i] = TU[v][i]; cx[i] = TX[v][i]; cn[i] = TN[v][i]; end
            for (int k = 0; k < TI[v] * IV; k++) one_cycle();
        end

        // mid-run reset returns r to +1 (R1)
        rst = 1'b1;
        @(posedge clk); #2;
        model_reset();
        check(r_neg == 1'b0 && r_exp == 5'sd0, "R1 reset after run");
        rst = 1'b0;

        // light load after reset: first step exactly at the window edge (R7), then R10
        for (int i = 0; i < NC; i++) begin cu[i] = 1; cx[i] = 0; cn[i] = 4; end
        for (int k = 0; k < 5 * IV; k++) one_cycle();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule